// File: doc/BRIEF.md
# Vector Narrowing Unit

This unit halves the width of every element of a 128-bit source vector and places the packed results into a 128-bit destination register image. Four narrowing modes are available. The first discards the upper half of each element. The second clamps a signed value into the signed range. The third clamps an unsigned value into the unsigned range. The fourth clamps a signed value into the unsigned range. The mode is picked by a 5-bit opcode together with an unsigned-select bit. A 2-bit size field picks the element width.

The source is handled as two 64-bit halves, and each half yields a packed 32-bit word. The upper-half select bit decides where the 64-bit result lands. When it is clear, the result goes into the low half of the destination and the high half is zeroed. When it is set, the result goes into the high half and the low half of the current destination value is preserved. A request is registered, and its result, per-element clamp flags, an undefined-encoding flag and a done strobe appear one cycle after the valid strobe. A sticky cumulative clamp flag gathers the per-element flags until it is cleared.

Top module: `vn_narrow_unit`

## Requirements
- R1: `done_o` is high exactly in the cycle after a cycle with `valid_i` high. In a cycle after one without `valid_i`, `done_o`, `undef_o` and all `sat_lane_o` bits are low and `dst_o` keeps its value.
- R2: Opcode 0x12 with `u_i`=0 keeps the low half of each source element and never raises a clamp flag.
- R3: Opcode 0x14 with `u_i`=0 reads each element as signed and clamps it to [-2^(n-1), 2^(n-1)-1], where n is the destination element width.
- R4: Opcode 0x14 with `u_i`=1 reads each element as unsigned and clamps it to [0, 2^n-1].
- R5: Opcode 0x12 with `u_i`=1 reads each element as signed. Negative values become 0, values above 2^n-1 become 2^n-1, and all other values pass through unchanged.
- R6: Size 0, 1 and 2 narrow 16-, 32- and 64-bit source elements to 8, 16 and 32 bits. Source element k, taken from bits [k*2n +: 2n], is written to destination bits [B + k*n +: n], where B is 0 or 64.
- R7: With `q_i`=0 the result sits at B=0, and `dst_o[127:64]` is zero.
- R8: With `q_i`=1 the result sits at B=64, and `dst_o[63:0]` equals `dst_i[63:0]` of the request.
- R9: Size 3 is undefined. `undef_o` is set, `dst_o` equals the request's `dst_i`, all `sat_lane_o` bits are zero, and `sat_cum_o` is not set by the request.
- R10: Any opcode other than 0x12 and 0x14 is undefined and behaves as in R9.
- R11: `sat_lane_o[k]` is set when clamping changed source element k. Bits at or above the element count (8, 4 or 2 for sizes 0, 1 and 2) are zero.
- R12: `sat_cum_o` is set by any request that raises a clamp flag, and it stays set until `sat_clr_i` is high at a clock edge. If a clear and a clamping request arrive at the same edge, the flag ends up set.
- R13: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| opcode_i | input | 5 | Operation code (0x12 or 0x14 legal) |
| u_i | input | 1 | Unsigned-select bit |
| q_i | input | 1 | Upper-half destination select |
| size_i | input | 2 | Destination element size code |
| src_i | input | 128 | Source vector |
| dst_i | input | 128 | Current destination value |
| sat_clr_i | input | 1 | Clears the sticky clamp flag |
| dst_o | output | 128 | New destination value |
| sat_lane_o | output | 8 | Per-element clamp flags |
| sat_cum_o | output | 1 | Sticky cumulative clamp flag |
| undef_o | output | 1 | Undefined encoding flag |
| done_o | output | 1 | Result strobe |

## Verification
The bench builds the unit with its default 128-bit vector width, so all three element sizes and both destination halves are in play. At byte size, every 16-bit source value passes through all four modes with both half selects: 8192 vectors of eight distinct elements cover the whole input space. The 32- and 64-bit sizes are swept over values clustered within two of each clamp threshold and of the sign boundary, in every element position. Undefined opcodes and sizes, idle cycles, and the clear-versus-set ordering of the sticky flag are driven directly.

// File: rtl/vn_narrow_pkg.sv
package vn_narrow_pkg;

    localparam int unsigned VEC_W_DEFAULT = 128;
    localparam int unsigned NUM_SIZES     = 3;

    localparam logic [4:0] OPC_EXTRACT = 5'h12;
    localparam logic [4:0] OPC_SATNAR  = 5'h14;
    localparam logic [1:0] SIZE_RSVD   = 2'd3;

    typedef enum logic [1:0] {
        NM_TRUNC = 2'd0,
        NM_SS    = 2'd1,
        NM_UU    = 2'd2,
        NM_SU    = 2'd3
    } nmode_e;

    typedef struct packed {
        logic   legal;
        nmode_e mode;
    } ndec_t;

    function automatic ndec_t decode_narrow(input logic [4:0] opc,
                                            input logic       uns,
                                            input logic [1:0] sz);
        ndec_t d;
        d.legal = 1'b0;
        d.mode  = NM_TRUNC;
        if (sz != SIZE_RSVD) begin
            if (opc == OPC_EXTRACT) begin
                d.legal = 1'b1;
                d.mode  = uns ? NM_SU : NM_TRUNC;
            end else if (opc == OPC_SATNAR) begin
                d.legal = 1'b1;
                d.mode  = uns ? NM_UU : NM_SS;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/vn_decode.sv
module vn_decode
    import vn_narrow_pkg::*;
(
    input  logic [4:0] opcode,
    input  logic       uns,
    input  logic [1:0] size,
    output ndec_t      dec
);
    always_comb begin
        dec = decode_narrow(opcode, uns, size);
    end
endmodule

// File: rtl/vn_lane.sv
module vn_lane
    import vn_narrow_pkg::*;
#(
    parameter int unsigned SRC_W = 16
) (
    input  nmode_e             mode,
    input  logic [SRC_W-1:0]   src,
    output logic [SRC_W/2-1:0] res,
    output logic               sat
);
    localparam int unsigned DW = SRC_W / 2;

    logic [DW-1:0] low_part;
    logic [DW-1:0] high_part;
    logic [DW:0]   sign_field;
    logic          fits_signed;
    logic          fits_unsigned;
    logic          neg;

    always_comb begin
        low_part      = src[DW-1:0];
        high_part     = src[SRC_W-1:DW];
        sign_field    = src[SRC_W-1:DW-1];
        neg           = src[SRC_W-1];
        fits_signed   = (&sign_field) | ~(|sign_field);
        fits_unsigned = ~(|high_part);
        res = low_part;
        sat = 1'b0;
        unique case (mode)
            NM_TRUNC: begin
                res = low_part;
                sat = 1'b0;
            end
            NM_SS: begin
                if (!fits_signed) begin
                    res = neg ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
                    sat = 1'b1;
                end
            end
            NM_UU: begin
                if (!fits_unsigned) begin
                    res = '1;
                    sat = 1'b1;
                end
            end
            NM_SU: begin
                if (neg) begin
                    res = '0;
                    sat = 1'b1;
                end else if (!fits_unsigned) begin
                    res = '1;
                    sat = 1'b1;
                end
            end
            default: begin
                res = low_part;
                sat = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vn_half.sv
module vn_half
    import vn_narrow_pkg::*;
#(
    parameter int unsigned HALF_W = 64
) (
    input  nmode_e                  mode,
    input  logic [1:0]              size,
    input  logic [HALF_W-1:0]       src,
    output logic [HALF_W/2-1:0]     res,
    output logic [HALF_W/16-1:0]    sat
);
    localparam int unsigned RES_W = HALF_W / 2;
    localparam int unsigned NF    = RES_W / 8;

    logic [NUM_SIZES*RES_W-1:0] res_all;
    logic [NUM_SIZES*NF-1:0]    sat_all;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int unsigned DW = 8 << s;
        localparam int unsigned N  = RES_W / DW;
        logic [RES_W-1:0] r;
        logic [N-1:0]     f;
        for (genvar j = 0; j < N; j++) begin : g_lane
            vn_lane #(.SRC_W(2 * DW)) u_lane (
                .mode (mode),
                .src  (src[j*2*DW +: 2*DW]),
                .res  (r[j*DW +: DW]),
                .sat  (f[j])
            );
        end
        assign res_all[s*RES_W +: RES_W] = r;
        assign sat_all[s*NF +: NF]       = NF'(f);
    end

    always_comb begin
        res = '0;
        sat = '0;
        for (int s = 0; s < NUM_SIZES; s++) begin
            if (size == 2'(s)) begin
                res = res_all[s*RES_W +: RES_W];
                sat = sat_all[s*NF +: NF];
            end
        end
    end
endmodule

// File: rtl/vn_narrow_unit.sv
module vn_narrow_unit
    import vn_narrow_pkg::*;
#(
    parameter int unsigned VEC_W = VEC_W_DEFAULT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic [4:0]         opcode_i,
    input  logic               u_i,
    input  logic               q_i,
    input  logic [1:0]         size_i,
    input  logic [VEC_W-1:0]   src_i,
    input  logic [VEC_W-1:0]   dst_i,
    input  logic               sat_clr_i,
    output logic [VEC_W-1:0]   dst_o,
    output logic [VEC_W/16-1:0] sat_lane_o,
    output logic               sat_cum_o,
    output logic               undef_o,
    output logic               done_o
);
    localparam int unsigned HALF_W = VEC_W / 2;
    localparam int unsigned RES_W  = HALF_W / 2;
    localparam int unsigned NF     = RES_W / 8;
    localparam int unsigned LANES  = 2 * NF;

    ndec_t                    dec;
    logic [1:0][RES_W-1:0]    half_res;
    logic [1:0][NF-1:0]       half_sat;
    logic [LANES-1:0]         lanes_n;
    logic [VEC_W-1:0]         dst_n;

    logic [VEC_W-1:0]         dst_q;
    logic [LANES-1:0]         lanes_q;
    logic                     cum_q;
    logic                     undef_q;
    logic                     done_q;

    vn_decode u_dec (
        .opcode (opcode_i),
        .uns    (u_i),
        .size   (size_i),
        .dec    (dec)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        vn_half #(.HALF_W(HALF_W)) u_half (
            .mode (dec.mode),
            .size (size_i),
            .src  (src_i[h*HALF_W +: HALF_W]),
            .res  (half_res[h]),
            .sat  (half_sat[h])
        );
    end

    // Element numbering runs across both halves: the low half supplies
    // the first (NF >> size) elements, the high half the next ones.
    always_comb begin
        int unsigned per_half;
        per_half = NF >> size_i;
        lanes_n  = '0;
        for (int h = 0; h < 2; h++) begin
            for (int j = 0; j < int'(NF); j++) begin
                if (j < int'(per_half)) begin
                    lanes_n[h*per_half + j] = half_sat[h][j];
                end
            end
        end
    end

    always_comb begin
        if (q_i) begin
            dst_n = {half_res[1], half_res[0], dst_i[HALF_W-1:0]};
        end else begin
            dst_n = {{HALF_W{1'b0}}, half_res[1], half_res[0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_q   <= '0;
            lanes_q <= '0;
            cum_q   <= 1'b0;
            undef_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q  <= valid_i;
            undef_q <= valid_i && !dec.legal;
            lanes_q <= (valid_i && dec.legal) ? lanes_n : '0;
            cum_q   <= (sat_clr_i ? 1'b0 : cum_q) | (valid_i && dec.legal && (|lanes_n));
            if (valid_i) begin
                dst_q <= dec.legal ? dst_n : dst_i;
            end
        end
    end

    assign dst_o      = dst_q;
    assign sat_lane_o = lanes_q;
    assign sat_cum_o  = cum_q;
    assign undef_o    = undef_q;
    assign done_o     = done_q;

endmodule

// File: rtl/vn_narrow_unit_chk.sv
module vn_narrow_unit_chk #(
    parameter int unsigned VEC_W = 128
) (
    input logic                clk,
    input logic                rst,
    input logic                valid_i,
    input logic [4:0]          opcode_i,
    input logic                u_i,
    input logic                q_i,
    input logic [1:0]          size_i,
    input logic [VEC_W-1:0]    src_i,
    input logic [VEC_W-1:0]    dst_i,
    input logic                sat_clr_i,
    input logic [VEC_W-1:0]    dst_o,
    input logic [VEC_W/16-1:0] sat_lane_o,
    input logic                sat_cum_o,
    input logic                undef_o,
    input logic                done_o
);
    localparam int unsigned HALF_W = VEC_W / 2;
    localparam int unsigned LANES  = VEC_W / 16;

    logic opc_ok;
    logic req_ok;
    assign opc_ok = (opcode_i == 5'h12) || (opcode_i == 5'h14);
    assign req_ok = valid_i && opc_ok && (size_i != 2'd3);

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> done_o); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!done_o && !undef_o && sat_lane_o == '0 && $stable(dst_o))); // R1

    AST_TRUNC_NO_SAT: assert property (@(posedge clk) disable iff (rst)
        (req_ok && opcode_i == 5'h12 && !u_i) |=> (sat_lane_o == '0)); // R2

    AST_LOW_CLEAR_HIGH: assert property (@(posedge clk) disable iff (rst)
        (req_ok && !q_i) |=> (dst_o[VEC_W-1:HALF_W] == '0)); // R7

    AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
        (req_ok && q_i) |=> (dst_o[HALF_W-1:0] == $past(dst_i[HALF_W-1:0]))); // R8

    AST_SIZE_RSVD_UNDEF: assert property (@(posedge clk) disable iff (rst)
        (valid_i && size_i == 2'd3) |=> (undef_o && sat_lane_o == '0 && dst_o == $past(dst_i))); // R9

    AST_OPCODE_UNDEF: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !opc_ok) |=> (undef_o && sat_lane_o == '0 && dst_o == $past(dst_i))); // R10

    AST_WIDE_LANES_UNUSED: assert property (@(posedge clk) disable iff (rst)
        (req_ok && size_i == 2'd2) |=> (sat_lane_o[LANES-1:2] == '0)); // R11

    AST_STICKY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (sat_lane_o != '0) |-> sat_cum_o); // R12

    AST_STICKY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sat_clr_i && !valid_i) |=> !sat_cum_o); // R12

    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sat_cum_o && !sat_clr_i) |=> sat_cum_o); // R12

endmodule

bind vn_narrow_unit vn_narrow_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .opcode_i   (opcode_i),
    .u_i        (u_i),
    .q_i        (q_i),
    .size_i     (size_i),
    .src_i      (src_i),
    .dst_i      (dst_i),
    .sat_clr_i  (sat_clr_i),
    .dst_o      (dst_o),
    .sat_lane_o (sat_lane_o),
    .sat_cum_o  (sat_cum_o),
    .undef_o    (undef_o),
    .done_o     (done_o)
);

// File: tb/vn_narrow_unit_test.sv
`timescale 1ns/1ps
module vn_narrow_unit_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_i = 1'b0;
    logic [4:0]   opcode_i = '0;
    logic         u_i = 1'b0;
    logic         q_i = 1'b0;
    logic [1:0]   size_i = '0;
    logic [127:0] src_i = '0;
    logic [127:0] dst_i = '0;
    logic         sat_clr_i = 1'b0;
    logic [127:0] dst_o;
    logic [7:0]   sat_lane_o;
    logic         sat_cum_o;
    logic         undef_o;
    logic         done_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic         exp_cum = 1'b0;
    logic [127:0] last_dst = '0;

    always #5 clk = ~clk;

    vn_narrow_unit uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .opcode_i(opcode_i),
        .u_i(u_i), .q_i(q_i), .size_i(size_i), .src_i(src_i), .dst_i(dst_i),
        .sat_clr_i(sat_clr_i), .dst_o(dst_o), .sat_lane_o(sat_lane_o),
        .sat_cum_o(sat_cum_o), .undef_o(undef_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Arithmetic reference: clamp ranges from the requirements.
    task automatic model(input logic [4:0] opc, input logic u, input logic q,
                         input logic [1:0] sz, input logic [127:0] src,
                         input logic [127:0] dst, output logic [127:0] edst,
                         output logic [7:0] elanes, output logic eundef);
        logic [63:0] res64;
        int n, sw, cnt;
        elanes = '0;
        if (sz == 2'd3 || (opc != 5'h12 && opc != 5'h14)) begin
            edst = dst;
            eundef = 1'b1;
            return;
        end
        eundef = 1'b0;
        n = 8 << sz;
        sw = 2 * n;
        cnt = 128 / sw;
        res64 = '0;
        for (int k = 0; k < cnt; k++) begin
            logic [127:0] sh;
            longint unsigned uv, umax, r;
            longint sv, smax, smin;
            bit s;
            sh = src >> (k * sw);
            uv = (sw == 64) ? sh[63:0] : (sh[63:0] & ((64'd1 << sw) - 64'd1));
            if (sw == 64) sv = $signed(uv);
            else sv = uv[sw-1] ? (longint'(uv) - (longint'(1) << sw)) : longint'(uv);
            umax = (64'd1 << n) - 64'd1;
            smax = (longint'(1) << (n - 1)) - 1;
            smin = -(longint'(1) << (n - 1));
            s = 1'b0;
            r = uv & umax;
            if (opc == 5'h14 && !u) begin
                if (sv > smax) begin r = longint'(smax); s = 1; end
                else if (sv < smin) begin r = longint'(smin) & umax; s = 1; end
            end else if (opc == 5'h14 && u) begin
                if (uv > umax) begin r = umax; s = 1; end
            end else if (opc == 5'h12 && u) begin
                if (sv < 0) begin r = 0; s = 1; end
                else if (sv > longint'(umax)) begin r = umax; s = 1; end
            end
            res64 = res64 | ((r & umax) << (k * n));
            elanes[k] = s;
        end
        edst = q ? {res64, dst[63:0]} : {64'd0, res64};
    endtask

    function automatic string mode_tag(input logic [4:0] opc, input logic u);
        if (opc == 5'h12 && !u) return "R2";
        if (opc == 5'h14 && !u) return "R3";
        if (opc == 5'h14 && u)  return "R4";
        return "R5";
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic do_op(input logic [4:0] opc, input logic u, input logic q,
                         input logic [1:0] sz, input logic [127:0] src,
                         input logic [127:0] dst, input logic clr);
        logic [127:0] edst;
        logic [7:0]   el;
        logic         eu;
        string        tg;
        valid_i = 1'b1; opcode_i = opc; u_i = u; q_i = q; size_i = sz;
        src_i = src; dst_i = dst; sat_clr_i = clr;
        model(opc, u, q, sz, src, dst, edst, el, eu);
        exp_cum = (clr ? 1'b0 : exp_cum) | (|el);
        @(negedge clk);
        valid_i = 1'b0; sat_clr_i = 1'b0;
        chk(done_o === 1'b1, "R1 done", 128'(done_o), 128'd1);
        chk(undef_o === eu, (sz == 2'd3) ? "R9 undef" : "R10 undef", 128'(undef_o), 128'(eu));
        chk(sat_lane_o === el, "R11 lanes", 128'(sat_lane_o), 128'(el));
        chk(sat_cum_o === exp_cum, "R12 sticky", 128'(sat_cum_o), 128'(exp_cum));
        if (eu) begin
            chk(dst_o === edst, (sz == 2'd3) ? "R9 dst" : "R10 dst", dst_o, edst);
        end else begin
            tg = mode_tag(opc, u);
            if (q) begin
                chk(dst_o[127:64] === edst[127:64], {tg, " R6 high"}, dst_o, edst);
                chk(dst_o[63:0] === edst[63:0], "R8 low kept", dst_o, edst);
            end else begin
                chk(dst_o[63:0] === edst[63:0], {tg, " R6 low"}, dst_o, edst);
                chk(dst_o[127:64] === 64'd0, "R7 high zero", dst_o, edst);
            end
        end
        last_dst = edst;
    endtask

    function automatic logic [63:0] edge_val(input int idx, input int sz);
        int n, sw;
        logic [63:0] base, v;
        n = 8 << sz;
        sw = 2 * n;
        case (idx / 5)
            0: base = 64'd0;
            1: base = 64'd1 << (n - 1);
            2: base = 64'd1 << n;
            3: base = 64'd1 << (sw - 1);
            default: base = -(64'd1 << (n - 1));
        endcase
        v = base + 64'(idx % 5) - 64'd2;
        if (sw < 64) v = v & ((64'd1 << sw) - 64'd1);
        return v;
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] src, dst;
        logic [4:0]   opcs [4];
        logic         us   [4];
        opcs[0] = 5'h12; us[0] = 1'b0;
        opcs[1] = 5'h14; us[1] = 1'b0;
        opcs[2] = 5'h14; us[2] = 1'b1;
        opcs[3] = 5'h12; us[3] = 1'b1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(dst_o === '0, "R13 dst", dst_o, '0);
        chk(sat_lane_o === '0 && sat_cum_o === 1'b0, "R13 flags",
            {sat_lane_o, sat_cum_o}, '0);
        chk(undef_o === 1'b0 && done_o === 1'b0, "R13 strobes", {undef_o, done_o}, '0);

        // R6 exhaustive byte-size sweep over all 16-bit values
        for (int i = 0; i < 8192; i++) begin
            for (int k = 0; k < 8; k++) src[k*16 +: 16] = 16'(i * 8 + k);
            dst = {4{32'(i) * 32'h9E3779B9}};
            for (int m = 0; m < 4; m++) begin
                do_op(opcs[m], us[m], 1'b0, 2'd0, src, dst, 1'b0);
                do_op(opcs[m], us[m], 1'b1, 2'd0, src, dst, 1'b0);
            end
        end

        // R6 word size: all pairs of threshold values
        for (int a = 0; a < 25; a++) begin
            for (int b = 0; b < 25; b++) begin
                src = {edge_val(b, 2), edge_val(a, 2)};
                dst = {32'h1234_5678, 32'(a), 32'(b), 32'hCAFE_F00D};
                for (int m = 0; m < 4; m++) begin
                    do_op(opcs[m], us[m], 1'b0, 2'd2, src, dst, 1'b0);
                    do_op(opcs[m], us[m], 1'b1, 2'd2, src, dst, 1'b0);
                end
            end
        end

        // R6 halfword size: threshold values rotated through positions
        for (int i = 0; i < 125; i++) begin
            for (int k = 0; k < 4; k++)
                src[k*32 +: 32] = edge_val((i + k * 7 + (i / 25) * k) % 25, 1)[31:0];
            dst = {4{32'(i) ^ 32'hA5A5_5A5A}};
            for (int m = 0; m < 4; m++) begin
                do_op(opcs[m], us[m], 1'b0, 2'd1, src, dst, 1'b0);
                do_op(opcs[m], us[m], 1'b1, 2'd1, src, dst, 1'b0);
            end
        end

        // R9 reserved size with every mode
        for (int m = 0; m < 4; m++)
            do_op(opcs[m], us[m], 1'(m), 2'd3, {8{16'h8001}}, {4{32'h0BAD_BEEF}}, 1'b0);

        // R10 every other opcode
        for (int o = 0; o < 32; o++) begin
            if (o != 'h12 && o != 'h14)
                do_op(5'(o), 1'(o), 1'b0, 2'd0, {8{16'h7FFF}}, {4{32'(o)}}, 1'b0);
        end

        // R1 idle cycle: strobes low, destination held
        @(negedge clk);
        chk(done_o === 1'b0 && undef_o === 1'b0 && sat_lane_o === '0, "R1 idle strobes",
            {done_o, undef_o, sat_lane_o}, '0);
        chk(dst_o === last_dst, "R1 idle hold", dst_o, last_dst);

        // R12 clear alone, clear with truncation, clear with clamping request
        do_op(5'h14, 1'b0, 1'b0, 2'd0, {8{16'h7FFF}}, '0, 1'b0);
        sat_clr_i = 1'b1;
        @(negedge clk);
        sat_clr_i = 1'b0;
        exp_cum = 1'b0;
        chk(sat_cum_o === 1'b0, "R12 clear", 128'(sat_cum_o), 128'd0);
        do_op(5'h12, 1'b0, 1'b0, 2'd0, {8{16'hFFFF}}, '0, 1'b1);
        do_op(5'h14, 1'b1, 1'b1, 2'd0, {8{16'h0100}}, '0, 1'b1);
        chk(sat_cum_o === 1'b1, "R12 set wins", 128'(sat_cum_o), 128'd1);
        do_op(5'h12, 1'b0, 1'b0, 2'd1, {4{32'hFFFF_0000}}, '0, 1'b0);
        chk(sat_cum_o === 1'b1, "R12 held", 128'(sat_cum_o), 128'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule